// File: doc/BRIEF.md
# Body Bias Transition Controller

This block moves a voltage domain between forward and reverse transistor body bias. Software programs it through four word registers on a small memory-mapped bus. Writes take effect at the clock edge; reads are combinational. A setup register holds the global enable, the two active-type selects and a settling count. A control register holds two mode selects and a change-request bit.

When software sets the change-request bit together with exactly one mode select, and the block is enabled and idle, the block latches that mode. It then drives the matching bias-enable output toward the external regulator and starts a settling wait. The wait runs for a programmed number of ticks, and each tick is a fixed number of system-clock cycles. When the wait ends, a sticky done flag is set, which software clears by writing 1 to it. The done flag can also raise a level interrupt when the interrupt enable is set.

The normal sequence is as follows. Software clears done, programs setup, issues the request, waits for done, then clears done again. Writing zero to setup, or zero to control while idle, returns the block to the bias-off state.

Top module: `bias_xition_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `fbb_en_o`, `rbb_en_o` and `done_irq_o` are low.
- R2: Word address 0 is setup: bit 0 enable, bit 1 forward-type select, bit 2 reverse-type select, bits 15:8 settling count. Address 1 is control: bit 0 fast mode, bit 1 slow mode, bit 2 change request. Address 2 is status, with done in bit 0. Address 3 is the interrupt enable, in bit 0. Setup reads back as written in those fields, and all other bits read 0.
- R3: A control write is accepted as a request when all of the following hold: bit 2 is 1, exactly one of bits 1:0 is 1, setup enable is 1, and no transition is in progress. From the next cycle, `fbb_en_o` = fast mode AND forward-type select, and `rbb_en_o` = slow mode AND reverse-type select.
- R4: With settling count N and TICK_CYC cycles per tick, done first reads 1 exactly (N+1)*TICK_CYC cycles after the accepting edge, and reads 0 one cycle earlier. A count of 0 therefore completes after one tick.
- R5: While a transition is in progress, control bit 2 reads 1 and bits 1:0 read the latched mode. When the transition completes, bit 2 reads 0 again.
- R6: A control write made while a transition is in progress has no effect on the outputs or the latched mode.
- R7: A request with both mode bits set or with neither set is ignored: the outputs do not change and done is not raised.
- R8: While setup enable is 0, the bias outputs are low and requests are ignored. Clearing enable abandons a transition in progress without raising done. A control write of 0 while idle clears the latched mode and drops the outputs. A control write with bit 2 at 0 and a nonzero mode is ignored.
- R9: Done holds until a status write with bit 0 at 1 clears it. A status write with bit 0 at 0 leaves it unchanged.
- R10: `done_irq_o` is high exactly when done is 1 and the interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr_i | input | 2 | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| fbb_en_o | output | 1 | Forward body bias enable to the regulator |
| rbb_en_o | output | 1 | Reverse body bias enable to the regulator |
| done_irq_o | output | 1 | Level interrupt: done gated by interrupt enable |

## Verification
The hardest cases to reach are the ones inside the settling window: a second control write landing in the middle of a transition, and an enable drop that abandons it. Both require a bus write at a precise cycle between acceptance and expiry. The stimulus places a conflicting request in the cycle right after acceptance. It then samples done one cycle before and at the computed expiry cycle. Random setup and control values, including invalid mode pairs and a disabled block, run alongside directed cases for a zero count and for the abort.

// File: rtl/bias_pkg.sv
package bias_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;
  localparam int CNT_LSB = 8;

  localparam logic [ADDR_W-1:0] A_SETUP = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_IRQEN = 2'd3;

  typedef struct packed {
    logic [CNT_W-1:0] settle;
    logic             rev_sel;
    logic             fwd_sel;
    logic             en;
  } setup_t;

  // latched mode: bit 0 fast (forward), bit 1 slow (reverse)
  typedef logic [1:0] mode_t;
endpackage

// File: rtl/bias_settle_timer.sv
module bias_settle_timer
  import bias_pkg::*;
#(
  parameter int TICK_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_CYC - 1);

  logic [PW-1:0]    presc_q;
  logic [CNT_W-1:0] rem_q;
  logic             busy_q;
  logic             tick;

  assign tick   = busy_q && (presc_q == PRESC_LAST);
  assign done_o = tick && (rem_q == '0) && !abort_i;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      presc_q <= '0;
      rem_q   <= '0;
    end else if (abort_i) begin
      busy_q  <= 1'b0;
      presc_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      presc_q <= '0;
      rem_q   <= count_i;
    end else if (busy_q) begin
      if (tick) begin
        presc_q <= '0;
        if (rem_q == '0) busy_q <= 1'b0;
        else             rem_q  <= rem_q - 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  p_presc_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (int'(presc_q) < TICK_CYC));

  p_rem_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick && !abort_i && !start_i) |=> $stable(rem_q));

  p_start_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/bias_regs.sv
module bias_regs
  import bias_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_set_i,
  output setup_t            setup_o,
  output mode_t             mode_o,
  output logic              start_o,
  output logic              abort_o,
  output logic              done_o,
  output logic              irq_en_o
);
  setup_t setup_q;
  mode_t  mode_q;
  logic   done_q;
  logic   irq_en_q;

  logic wr_setup, wr_ctrl, wr_stat, wr_irq;
  logic ctrl_chg;
  mode_t ctrl_mode;
  logic unused_wdata;

  assign wr_setup  = we_i && (addr_i == A_SETUP);
  assign wr_ctrl   = we_i && (addr_i == A_CTRL);
  assign wr_stat   = we_i && (addr_i == A_STAT);
  assign wr_irq    = we_i && (addr_i == A_IRQEN);
  assign ctrl_mode = wdata_i[1:0];
  assign ctrl_chg  = wdata_i[2];
  assign unused_wdata = ^{wdata_i[DATA_W-1:CNT_LSB+CNT_W], wdata_i[CNT_LSB-1:3]};

  assign abort_o = !setup_q.en;
  assign start_o = wr_ctrl && !busy_i && ctrl_chg && (ctrl_mode[0] ^ ctrl_mode[1])
                   && setup_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q  <= '0;
      mode_q   <= '0;
      done_q   <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (wr_setup) begin
        setup_q.en      <= wdata_i[0];
        setup_q.fwd_sel <= wdata_i[1];
        setup_q.rev_sel <= wdata_i[2];
        setup_q.settle  <= wdata_i[CNT_LSB +: CNT_W];
      end
      if (!setup_q.en)
        mode_q <= '0;
      else if (start_o)
        mode_q <= ctrl_mode;
      else if (wr_ctrl && !busy_i && (wdata_i[2:0] == 3'b000))
        mode_q <= '0;
      if (done_set_i)
        done_q <= 1'b1;
      else if (wr_stat && wdata_i[0])
        done_q <= 1'b0;
      if (wr_irq) irq_en_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_SETUP: begin
        rdata_o[0] = setup_q.en;
        rdata_o[1] = setup_q.fwd_sel;
        rdata_o[2] = setup_q.rev_sel;
        rdata_o[CNT_LSB +: CNT_W] = setup_q.settle;
      end
      A_CTRL:  rdata_o[2:0] = {busy_i, mode_q};
      A_STAT:  rdata_o[0]   = done_q;
      A_IRQEN: rdata_o[0]   = irq_en_q;
      default: rdata_o = '0;
    endcase
  end

  assign setup_o  = setup_q;
  assign mode_o   = mode_q;
  assign done_o   = done_q;
  assign irq_en_o = irq_en_q;

  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !(wr_stat && wdata_i[0])) |=> done_q);

  p_done_from_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(busy_i));

  p_busy_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_ctrl && setup_q.en) |=> $stable(mode_q));

  p_mode_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mode_q));
endmodule

// File: rtl/bias_xition_ctrl.sv
module bias_xition_ctrl
  import bias_pkg::*;
#(
  parameter int TICK_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              fbb_en_o,
  output logic              rbb_en_o,
  output logic              done_irq_o
);
  setup_t setup;
  mode_t  mode;
  logic   start, abort, busy, done_set, done, irq_en;

  bias_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .busy_i     (busy),
    .done_set_i (done_set),
    .setup_o    (setup),
    .mode_o     (mode),
    .start_o    (start),
    .abort_o    (abort),
    .done_o     (done),
    .irq_en_o   (irq_en)
  );

  bias_settle_timer #(.TICK_CYC(TICK_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .abort_i (abort),
    .count_i (setup.settle),
    .busy_o  (busy),
    .done_o  (done_set)
  );

  assign fbb_en_o   = setup.en && setup.fwd_sel && mode[0];
  assign rbb_en_o   = setup.en && setup.rev_sel && mode[1];
  assign done_irq_o = done && irq_en;

  p_bias_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fbb_en_o && rbb_en_o));

  p_off_when_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_SETUP && !bus_wdata_i[0]) |=> (!fbb_en_o && !rbb_en_o));

  p_irq_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_irq_o) |-> (done && irq_en));
endmodule

// File: tb/bias_xition_ctrl_bench.sv
module bias_xition_ctrl_bench;
  localparam int TICK = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fbb, rbb, irq;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  bias_xition_ctrl #(.TICK_CYC(TICK)) u_bias_xition_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .fbb_en_o(fbb), .rbb_en_o(rbb), .done_irq_o(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] exp_bias(input logic en, input logic fwd, input logic rev,
                                          input logic [1:0] m);
    return {en & rev & m[1], en & fwd & m[0]};
  endfunction

  function automatic logic [31:0] setup_word(input logic [7:0] c, input logic rev,
                                             input logic fwd, input logic en);
    return {16'h0, c, 5'h0, rev, fwd, en};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [1:0]  exp_m;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], r); chk("R1 reg", r, 32'h0);
    end
    chk("R1 outputs", {29'h0, fbb, rbb, irq}, 32'h0);

    // R2 field layout
    wr(2'd0, 32'hFFFF_AB07); rd(2'd0, r); chk("R2 setup readback", r, 32'h0000_AB07);
    wr(2'd0, 32'h0);

    // R4 zero count: one tick
    wr(2'd0, setup_word(8'd0, 1'b0, 1'b1, 1'b1));
    wr(2'd1, 32'h5);
    chk("R3 fbb after accept", {30'h0, rbb, fbb}, 32'h1);
    wait_cyc(TICK - 1); rd(2'd2, r); chk("R4 cnt0 before", r, 32'h0);
    wait_cyc(1);        rd(2'd2, r); chk("R4 cnt0 at tick", r, 32'h1);
    // R8 zero control when idle drops outputs
    wr(2'd1, 32'h0);
    chk("R8 ctrl zero", {30'h0, rbb, fbb}, 32'h0);
    wr(2'd2, 32'h1);

    // R8 abort by clearing enable
    wr(2'd0, setup_word(8'd5, 1'b1, 1'b0, 1'b1));
    wr(2'd1, 32'h6);
    chk("R3 rbb after accept", {30'h0, rbb, fbb}, 32'h2);
    wr(2'd0, 32'h0);
    chk("R8 enable drop", {30'h0, rbb, fbb}, 32'h0);
    wait_cyc(60); rd(2'd2, r); chk("R8 abort no done", r, 32'h0);
    rd(2'd1, r); chk("R8 abort idle", r, 32'h0);

    // R8 disabled request ignored
    wr(2'd0, setup_word(8'd0, 1'b1, 1'b1, 1'b0));
    wr(2'd1, 32'h5);
    wait_cyc(20); rd(2'd2, r); chk("R8 disabled req", {r[30:0], fbb}, 32'h0);

    exp_m = 2'b00;
    for (int it = 0; it < 40; it++) begin
      logic en, fwd, rev, chg, acc, ie;
      logic [7:0] cnt;
      logic [1:0] m;
      en  = ($urandom % 4) != 0;
      fwd = 1'($urandom % 2);
      rev = 1'($urandom % 2);
      cnt = 8'($urandom % 6);
      wr(2'd0, setup_word(cnt, rev, fwd, en));
      if (!en) exp_m = 2'b00;
      chk("R8 outputs after setup", {30'h0, rbb, fbb}, {30'h0, exp_bias(en, fwd, rev, exp_m)});
      m   = 2'($urandom % 4);
      chg = ($urandom % 5) != 0;
      wr(2'd1, {29'h0, chg, m});
      acc = chg && (m == 2'b01 || m == 2'b10) && en;
      if (acc) exp_m = m;
      else if (!chg && m == 2'b00 && en) exp_m = 2'b00;
      chk(acc ? "R3 outputs" : "R7 outputs", {30'h0, rbb, fbb},
          {30'h0, exp_bias(en, fwd, rev, exp_m)});
      if (acc) begin
        rd(2'd1, r); chk("R5 busy readback", r, {29'h0, 1'b1, m});
        wr(2'd1, {29'h0, 1'b1, ~m});
        chk("R6 busy write", {30'h0, rbb, fbb}, {30'h0, exp_bias(en, fwd, rev, exp_m)});
        wait_cyc((int'(cnt) + 1) * TICK - 2);
        rd(2'd2, r); chk("R4 before expiry", r, 32'h0);
        wait_cyc(1);
        rd(2'd2, r); chk("R4 at expiry", r, 32'h1);
        rd(2'd1, r); chk("R5 self clear", r, {29'h0, 1'b0, m});
      end else begin
        wait_cyc(20);
        rd(2'd2, r); chk("R7 no done", r, 32'h0);
      end
      ie = 1'($urandom % 2);
      wr(2'd3, {31'h0, ie});
      chk("R10 irq", {31'h0, irq}, {31'h0, ie & acc});
      wr(2'd2, 32'h0);
      rd(2'd2, r); chk("R9 write0 keeps", r, {31'h0, acc});
      wr(2'd2, 32'h1);
      rd(2'd2, r); chk("R9 w1c", r, 32'h0);
      chk("R10 irq cleared", {31'h0, irq}, 32'h0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule